// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register File

This block is the software-visible register file of an I/O interrupt controller with a parameterised number of input pins (24 by default). The processor reaches it through two 32-bit bus offsets. One is an index-select register. The other is a data window that reaches whichever internal register the select value names. The internal registers are a 4-bit controller identifier, a fixed version word, an arbitration alias of the identifier, and one 64-bit redirection entry per pin. Each entry is seen through the window as two 32-bit halves.

Two status bits in every entry belong to the delivery logic and not to software: bit 12 (delivery pending) and bit 14 (level acknowledge outstanding). The delivery logic drives these bits through a dedicated side port. Software writes to the low half leave them untouched. Each software write to an entry produces a one-cycle update strobe that carries the entry number, so the delivery logic can re-read the routing it depends on.

Top module: `irq_redir_regfile`

## Requirements
- R1: Bus offset 0x00 is the select register: a write stores all 32 bits of data and a read returns them. Bus offset 0x10 is the window onto the register named by select bits 7:0. Any other bus offset reads 0 and a write to it changes nothing.
- R2: Window index 0x00 is the identifier. A write stores data bits 27:24. A read returns the stored 4 bits in positions 27:24, with all other bits 0.
- R3: Window index 0x01 always reads 0x00170011 (maximum entry number 23 in bits 23:16, version 0x11 in bits 7:0). Writes to it are ignored.
- R4: Window index 0x02 reads the same word as index 0x00. Writes to it are ignored.
- R5: Window indices 0x10 to 0x3F select entry (index-0x10)/2. An even index addresses bits 31:0 and an odd index addresses bits 63:32. A high-half write replaces bits 63:32 and keeps bits 31:0.
- R6: A low-half write stores data AND 0xFFFFAFFF into bits 31:0 and keeps the previous values of bit 12 and bit 14.
- R7: When the side-port enable is high, bit 12 and bit 14 of the named entry take the side-port values at the next clock edge. A software write to the same entry in the same cycle does not change those two bits.
- R8: In the cycle after each clock edge that writes an entry, the update strobe is high and carries that entry number. The strobe is low after every other edge.
- R9: Window indices that are not defined read 0. A write to one of them changes no register and raises no strobe.
- R10: After reset, the select register, the identifier, every entry and the strobe are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write enable for the bus access in this cycle |
| bus_addr | input | 8 | Bus byte offset (0x00 select, 0x10 window) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| st_we | input | 1 | Side-port status write enable |
| st_entry | input | 5 | Entry whose status bits the side port writes |
| st_pend | input | 1 | New value for entry bit 12 |
| st_ack | input | 1 | New value for entry bit 14 |
| upd_valid | output | 1 | Entry-update strobe |
| upd_entry | output | 5 | Entry number written by software |

## Verification
The bench builds the block with its default parameters: 24 pins, an 8-bit offset and a 32-bit word. With these values the last entry sits at window indices 0x3E/0x3F and the first undefined index is 0x40, so both ends of the window decode are reached, along with the version word that is derived from the pin count. The bench also covers the collision of a software low-half write and a side-port update on the same entry in one cycle, and compares every strobe against the entry numbers the bench expects.

// File: rtl/irqrf_pkg.sv
package irqrf_pkg;
  localparam int WIN_BASE  = 8'h10;
  localparam int IDX_ID    = 8'h00;
  localparam int IDX_VER   = 8'h01;
  localparam int IDX_ARB   = 8'h02;
  localparam int BIT_PEND  = 12;
  localparam int BIT_ACK   = 14;
  localparam logic [31:0] LO_SW_MASK = 32'hFFFF_AFFF;

  // Version word: max entry number in 23:16, version code 0x11 in 7:0.
  function automatic logic [31:0] ver_word(input int pins);
    logic [7:0] mx;
    mx = 8'(pins - 1);
    return {8'h00, mx, 8'h00, 8'h11};
  endfunction

  // Merge a software low-half write with the hardware-owned bits.
  function automatic logic [31:0] lo_merge(input logic [31:0] old_w,
                                           input logic [31:0] wd);
    return (old_w & ~LO_SW_MASK) | (wd & LO_SW_MASK);
  endfunction

  function automatic logic [31:0] id_word(input logic [3:0] id);
    return {4'h0, id, 24'h0};
  endfunction
endpackage

// File: rtl/irqrf_decode.sv
module irqrf_decode #(
  parameter int NUM_PINS = 24,
  parameter int EW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    idx,
  output logic          hit_id,
  output logic          hit_ver,
  output logic          hit_arb,
  output logic          hit_ent,
  output logic [EW-1:0] ent_num,
  output logic          ent_hi
);
  import irqrf_pkg::*;
  localparam int WIN_END = WIN_BASE + 2 * NUM_PINS;

  logic [7:0] off;

  always_comb begin
    off     = idx - 8'(WIN_BASE);
    hit_id  = (idx == 8'(IDX_ID));
    hit_ver = (idx == 8'(IDX_VER));
    hit_arb = (idx == 8'(IDX_ARB));
    hit_ent = (int'(idx) >= WIN_BASE) && (int'(idx) < WIN_END);
    ent_num = off[EW:1];
    ent_hi  = idx[0];
  end

  AST_DEC_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hit_id, hit_ver, hit_arb, hit_ent})); // R9
endmodule

// File: rtl/irqrf_bank.sv
module irqrf_bank #(
  parameter int NUM_PINS = 24,
  parameter int EW       = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_hi,
  input  logic [EW-1:0] wr_num,
  input  logic [31:0]   wdata,
  input  logic          st_we,
  input  logic [EW-1:0] st_entry,
  input  logic          st_pend,
  input  logic          st_ack,
  input  logic [EW-1:0] rd_num,
  input  logic          rd_hi,
  output logic [31:0]   rd_word
);
  import irqrf_pkg::*;

  logic [63:0] ent_q [NUM_PINS];
  logic [NUM_PINS-1:0] sw_hit;
  logic [NUM_PINS-1:0] side_hit;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_ent
    logic [63:0] nxt;
    assign sw_hit[i]   = wr_en && (wr_num == EW'(i));
    assign side_hit[i] = st_we && (st_entry == EW'(i));

    always_comb begin
      nxt = ent_q[i];
      if (sw_hit[i]) begin
        if (wr_hi) nxt[63:32] = wdata;
        else       nxt[31:0]  = lo_merge(ent_q[i][31:0], wdata);
      end
      if (side_hit[i]) begin
        nxt[BIT_PEND] = st_pend;
        nxt[BIT_ACK]  = st_ack;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ent_q[i] <= '0;
      else        ent_q[i] <= nxt;
    end

    AST_LO_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_hit[i] && !wr_hi && !side_hit[i]) |=>
        (ent_q[i][BIT_PEND] == $past(ent_q[i][BIT_PEND]) &&
         ent_q[i][BIT_ACK]  == $past(ent_q[i][BIT_ACK]))); // R6
    AST_HI_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_hit[i] && wr_hi && !side_hit[i]) |=>
        (ent_q[i][31:0] == $past(ent_q[i][31:0]))); // R5
    AST_SIDE_WIN: assert property (@(posedge clk) disable iff (!rst_n)
      side_hit[i] |=> (ent_q[i][BIT_ACK] == $past(st_ack) &&
                       ent_q[i][BIT_PEND] == $past(st_pend))); // R7
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!sw_hit[i] && !side_hit[i]) |=> $stable(ent_q[i])); // R9
  end

  always_comb begin
    rd_word = '0;
    for (int k = 0; k < NUM_PINS; k++) begin
      if (rd_num == EW'(k)) rd_word = rd_hi ? ent_q[k][63:32] : ent_q[k][31:0];
    end
  end
endmodule

// File: rtl/irq_redir_regfile.sv
module irq_redir_regfile #(
  parameter int NUM_PINS = 24,
  parameter int AW       = 8,
  parameter int EW       = $clog2(NUM_PINS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          st_we,
  input  logic [EW-1:0] st_entry,
  input  logic          st_pend,
  input  logic          st_ack,
  output logic          upd_valid,
  output logic [EW-1:0] upd_entry
);
  import irqrf_pkg::*;
  localparam logic [AW-1:0] OFF_SEL = AW'(8'h00);
  localparam logic [AW-1:0] OFF_WIN = AW'(8'h10);
  localparam logic [31:0]   VER     = ver_word(NUM_PINS);

  logic [31:0]   sel_q;
  logic [3:0]    id_q;
  logic          hit_id, hit_ver, hit_arb, hit_ent, ent_hi;
  logic [EW-1:0] ent_num;
  logic [31:0]   ent_word;
  logic          wr_sel, wr_win, wr_ent, wr_id;

  irqrf_decode #(.NUM_PINS(NUM_PINS), .EW(EW)) u_dec (
    .clk(clk), .rst_n(rst_n), .idx(sel_q[7:0]),
    .hit_id(hit_id), .hit_ver(hit_ver), .hit_arb(hit_arb),
    .hit_ent(hit_ent), .ent_num(ent_num), .ent_hi(ent_hi)
  );

  assign wr_sel = bus_wr && (bus_addr == OFF_SEL);
  assign wr_win = bus_wr && (bus_addr == OFF_WIN);
  assign wr_ent = wr_win && hit_ent;
  assign wr_id  = wr_win && hit_id;

  irqrf_bank #(.NUM_PINS(NUM_PINS), .EW(EW)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_ent), .wr_hi(ent_hi), .wr_num(ent_num), .wdata(bus_wdata),
    .st_we(st_we), .st_entry(st_entry), .st_pend(st_pend), .st_ack(st_ack),
    .rd_num(ent_num), .rd_hi(ent_hi), .rd_word(ent_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q     <= '0;
      id_q      <= '0;
      upd_valid <= 1'b0;
      upd_entry <= '0;
    end else begin
      if (wr_sel) sel_q <= bus_wdata;
      if (wr_id)  id_q  <= bus_wdata[27:24];
      upd_valid <= wr_ent;
      if (wr_ent) upd_entry <= ent_num;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == OFF_SEL) bus_rdata = sel_q;
    else if (bus_addr == OFF_WIN) begin
      if (hit_id || hit_arb) bus_rdata = id_word(id_q);
      else if (hit_ver)      bus_rdata = VER;
      else if (hit_ent)      bus_rdata = ent_word;
    end
  end

  AST_UPD_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ent |=> (upd_valid && upd_entry == $past(ent_num))); // R8
  AST_UPD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_ent |=> !upd_valid); // R8
  AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_id |=> $stable(id_q)); // R2
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel |=> $stable(sel_q)); // R1
endmodule

// File: tb/sim_irq_redir_regfile.sv
module sim_irq_redir_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        st_we = 1'b0;
  logic [4:0]  st_entry = '0;
  logic        st_pend = 1'b0, st_ack = 1'b0;
  logic        upd_valid;
  logic [4:0]  upd_entry;

  int n_chk = 0, n_fail = 0;
  bit rd_pend = 1'b0, done = 1'b0;
  logic [31:0] q_rd_val [$];
  string       q_rd_tag [$];
  int          q_upd [$];

  always #4 clk = ~clk;

  irq_redir_regfile u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .st_we(st_we),
    .st_entry(st_entry), .st_pend(st_pend), .st_ack(st_ack),
    .upd_valid(upd_valid), .upd_entry(upd_entry)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  // Monitor: compares reads and strobes one step after each rising edge.
  always @(posedge clk) begin
    #1;
    if (rst_n && !done) begin
      if (rd_pend) begin
        if (q_rd_val.size() == 0) chk("R1 read queue empty", 32'h1, 32'h0);
        else chk(q_rd_tag.pop_front(), bus_rdata, q_rd_val.pop_front());
      end
      if (upd_valid) begin
        if (q_upd.size() == 0) chk("R8/R9 unexpected strobe", {27'h0, upd_entry}, 32'hFFFFFFFF);
        else chk("R8 strobe entry", {27'h0, upd_entry}, q_upd.pop_front());
      end
    end
  end

  task automatic rd(logic [7:0] a, logic [31:0] exp, string tag);
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = a;
    q_rd_val.push_back(exp); q_rd_tag.push_back(tag);
    rd_pend = 1'b1;
    @(negedge clk);
    rd_pend = 1'b0;
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d, int exp_ent);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    if (exp_ent >= 0) q_upd.push_back(exp_ent);
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic side(logic [4:0] e, logic p, logic k);
    @(negedge clk);
    st_we = 1'b1; st_entry = e; st_pend = p; st_ack = k;
    @(negedge clk);
    st_we = 1'b0;
  endtask

  task automatic sel(logic [7:0] idx);
    wr(8'h00, {24'h0, idx}, -1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10 reset state
    chk("R10 strobe after reset", {31'h0, upd_valid}, 32'h0);
    rd(8'h00, 32'h0, "R10 select reset");
    rd(8'h10, 32'h0, "R10 id reset");
    sel(8'h10); rd(8'h10, 32'h0, "R10 entry0 low reset");
    sel(8'h3F); rd(8'h10, 32'h0, "R10 entry23 high reset");
    // R1 select readback
    wr(8'h00, 32'h1234_5601, -1);
    rd(8'h00, 32'h1234_5601, "R1 select readback");
    rd(8'h10, 32'h0017_0011, "R3 version via low select byte");
    // R3 version read-only
    wr(8'h10, 32'hFFFF_FFFF, -1);
    rd(8'h10, 32'h0017_0011, "R3 version after write");
    // R2 / R4 identifier and alias
    sel(8'h00); wr(8'h10, 32'hFFFF_FFFF, -1);
    rd(8'h10, 32'h0F00_0000, "R2 id masked");
    sel(8'h02); rd(8'h10, 32'h0F00_0000, "R4 arb alias");
    wr(8'h10, 32'h0, -1);
    sel(8'h00); rd(8'h10, 32'h0F00_0000, "R4 arb write ignored");
    wr(8'h10, 32'h0500_0000, -1);
    rd(8'h10, 32'h0500_0000, "R2 id rewrite");
    // R5 / R6 entry 5 low and high
    sel(8'h1A); wr(8'h10, 32'hFFFF_FFFF, 5);
    rd(8'h10, 32'hFFFF_AFFF, "R6 low write mask");
    side(5'd5, 1'b1, 1'b1);
    rd(8'h10, 32'hFFFF_FFFF, "R7 side sets status");
    wr(8'h10, 32'h0, 5);
    rd(8'h10, 32'h0000_5000, "R6 status preserved");
    sel(8'h1B); wr(8'h10, 32'hA500_0001, 5);
    rd(8'h10, 32'hA500_0001, "R5 high write");
    sel(8'h1A); rd(8'h10, 32'h0000_5000, "R5 low kept after high");
    side(5'd5, 1'b0, 1'b1);
    rd(8'h10, 32'h0000_4000, "R7 side clears pend");
    // R5 boundary: entry 23
    sel(8'h3E); wr(8'h10, 32'h0001_8A37, 23);
    rd(8'h10, 32'h0001_8A37, "R5 entry23 low");
    sel(8'h3F); wr(8'h10, 32'h0300_0000, 23);
    rd(8'h10, 32'h0300_0000, "R5 entry23 high");
    sel(8'h3E); rd(8'h10, 32'h0001_8A37, "R5 entry23 low intact");
    // R7 collision: software low write and side port same cycle on entry 3
    sel(8'h16);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 8'h10; bus_wdata = 32'h0000_50AB;
    st_we = 1'b1; st_entry = 5'd3; st_pend = 1'b0; st_ack = 1'b1;
    q_upd.push_back(3);
    @(negedge clk);
    bus_wr = 1'b0; st_we = 1'b0;
    rd(8'h10, 32'h0000_40AB, "R7 side wins collision");
    // R9 undefined indices and offsets
    sel(8'h40); wr(8'h10, 32'hFFFF_FFFF, -1);
    rd(8'h10, 32'h0, "R9 index 0x40 reads zero");
    sel(8'h03); wr(8'h10, 32'hFFFF_FFFF, -1);
    rd(8'h10, 32'h0, "R9 index 0x03 reads zero");
    sel(8'h0F); rd(8'h10, 32'h0, "R9 index 0x0F reads zero");
    wr(8'h04, 32'hFFFF_FFFF, -1);
    rd(8'h04, 32'h0, "R1 undefined offset reads zero");
    rd(8'h00, 32'h0000_000F, "R1 select after bad offset");
    sel(8'h00); rd(8'h10, 32'h0500_0000, "R9 id untouched");
    sel(8'h3E); rd(8'h10, 32'h0001_8A37, "R9 entry23 untouched");
    repeat (3) @(negedge clk);
    chk("R8 all strobes seen", q_upd.size(), 32'h0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule